// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a logical address made of a segment number and an offset into a physical address. It keeps a small table of segment descriptors. Each descriptor holds a physical start address, a segment length, a valid flag and three permission flags (read, write, execute). A separate length register says how many table slots the current context may use. Each translate request passes four checks before relocation: the segment number against the length register, the valid flag, the offset against the segment length, and the permission flag for the requested access type. An access that passes every check gets the start address plus the offset. The first check that fails raises a trap with a 2-bit cause code.

Software-side logic loads descriptors and the length register through a programming port. The memory pipeline issues one translate per cycle on the request port. The answer appears one cycle later, registered, on the response port.

The response side is a three-state machine. The states are RSP_IDLE (no answer this cycle), RSP_PASS (a good translation is presented) and RSP_TRAP (a trap is presented). The machine moves from any state to RSP_PASS on a request that clears all checks, to RSP_TRAP on a request that fails one, and to RSP_IDLE when no request is offered. Reset places it in RSP_IDLE.

Top module: `seg_xlat_unit`

## Requirements
- R1: After reset, rsp_valid is 0, the length register is 0 and every descriptor is invalid, so the first translate traps with cause 0.
- R2: A request accepted with req_valid=1 in cycle N gives rsp_valid=1 in cycle N+1 with its result. A cycle with req_valid=0 gives rsp_valid=0 in the next cycle, and back-to-back requests give back-to-back responses.
- R3: A segment number greater than or equal to the length register traps with cause 0 (2'b00), even when that slot holds a valid descriptor.
- R4: A segment whose valid flag is 0 traps with cause 1 (2'b01).
- R5: An offset greater than or equal to the segment length traps with cause 2 (2'b10). An offset of length minus one is accepted.
- R6: Access types are encoded as 0 read, 1 write, 2 execute and 3 reserved. Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. A missing permission, or access type 3, traps with cause 3 (2'b11).
- R7: When several checks fail, the cause reported is the first in this order: segment range, valid flag, offset length, permission.
- R8: A passing access gives rsp_trap=0, rsp_cause=0 and rsp_paddr equal to start address plus offset, modulo 2^PA_W.
- R9: A trapping access gives rsp_paddr=0.
- R10: Descriptor and length writes take effect on the cycle after they are issued. A translate issued in the same cycle as a write sees the old contents.
- R11: A descriptor write changes only the slot it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ent_we | input | 1 | Write one descriptor |
| cfg_ent_idx | input | SEG_W | Slot to write |
| cfg_base | input | PA_W | Physical start address |
| cfg_limit | input | OFF_W+1 | Segment length |
| cfg_valid | input | 1 | Valid flag |
| cfg_perm | input | 3 | Permission flags: bit 0 read, bit 1 write, bit 2 execute |
| cfg_len_we | input | 1 | Write the length register |
| cfg_len | input | SEG_W+1 | New length value |
| req_valid | input | 1 | Translate request present |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_trap | output | 1 | Access refused |
| rsp_cause | output | 2 | Trap cause code; 0 on a pass |
| rsp_paddr | output | PA_W | Physical address; 0 on a trap |

## Verification
A table update and a translate of the same slot can fall in the same cycle. So can a length update and a translate near the length boundary. The bench provokes both. It drives a descriptor write and a request for that descriptor on the same edge, and it does the same with a length write and a request for the slot just past the old length. It judges the response against the table contents from before the write. It then issues the same request again and expects the new contents to apply.

// File: rtl/segx_pkg.sv
package segx_pkg;

    typedef enum logic [1:0] {
        ACC_RD   = 2'd0,
        ACC_WR   = 2'd1,
        ACC_EX   = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_RANGE   = 2'd0,
        CAUSE_INVALID = 2'd1,
        CAUSE_LIMIT   = 2'd2,
        CAUSE_PERM    = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_PASS = 2'd1,
        RSP_TRAP = 2'd2
    } rsp_state_e;

    localparam int PERM_W = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W = 3,
    parameter int LIM_W = 11,
    parameter int PA_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ent_we,
    input  logic [SEG_W-1:0]            ent_idx,
    input  logic [PA_W-1:0]             ent_base,
    input  logic [LIM_W-1:0]            ent_limit,
    input  logic                        ent_valid,
    input  logic [segx_pkg::PERM_W-1:0] ent_perm,
    input  logic                        len_we,
    input  logic [SEG_W:0]              len_val,
    input  logic [SEG_W-1:0]            rd_idx,
    output logic [PA_W-1:0]             rd_base,
    output logic [LIM_W-1:0]            rd_limit,
    output logic                        rd_valid,
    output logic [segx_pkg::PERM_W-1:0] rd_perm,
    output logic [SEG_W:0]              len_q
);
    localparam int NSLOT = 1 << SEG_W;

    typedef struct packed {
        logic [PA_W-1:0]             base;
        logic [LIM_W-1:0]            limit;
        logic                        vld;
        logic [segx_pkg::PERM_W-1:0] perm;
    } slot_t;

    slot_t slot_view [NSLOT];
    slot_t picked;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        slot_t slot_q;
        logic  hit;
        assign hit = ent_we && (ent_idx == SEG_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (hit) begin
                slot_q.base  <= ent_base;
                slot_q.limit <= ent_limit;
                slot_q.vld   <= ent_valid;
                slot_q.perm  <= ent_perm;
            end
        end
        assign slot_view[g] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (len_we) begin
            len_q <= len_val;
        end
    end

    always_comb begin
        picked   = slot_view[rd_idx];
        rd_base  = picked.base;
        rd_limit = picked.limit;
        rd_valid = picked.vld;
        rd_perm  = picked.perm;
    end

endmodule

// File: rtl/seg_check.sv
module seg_check #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 10,
    parameter int PA_W  = 16
) (
    input  logic [SEG_W-1:0]            req_seg,
    input  logic [OFF_W-1:0]            req_off,
    input  logic [1:0]                  req_acc,
    input  logic [SEG_W:0]              len_q,
    input  logic [PA_W-1:0]             ent_base,
    input  logic [OFF_W:0]              ent_limit,
    input  logic                        ent_valid,
    input  logic [segx_pkg::PERM_W-1:0] ent_perm,
    output logic                        fail,
    output logic [1:0]                  cause,
    output logic [PA_W-1:0]             paddr
);
    import segx_pkg::*;

    logic   seg_ok;
    logic   lim_ok;
    logic   perm_ok;
    acc_e   acc;
    cause_e why;

    assign acc    = acc_e'(req_acc);
    assign seg_ok = {1'b0, req_seg} < len_q;
    assign lim_ok = {1'b0, req_off} < ent_limit;
    assign paddr  = ent_base + PA_W'(req_off);

    always_comb begin
        unique case (acc)
            ACC_RD:  perm_ok = ent_perm[0];
            ACC_WR:  perm_ok = ent_perm[1];
            ACC_EX:  perm_ok = ent_perm[2];
            default: perm_ok = 1'b0;
        endcase
    end

    always_comb begin
        fail = 1'b1;
        why  = CAUSE_RANGE;
        if (!seg_ok) begin
            why = CAUSE_RANGE;
        end else if (!ent_valid) begin
            why = CAUSE_INVALID;
        end else if (!lim_ok) begin
            why = CAUSE_LIMIT;
        end else if (!perm_ok) begin
            why = CAUSE_PERM;
        end else begin
            fail = 1'b0;
        end
    end

    assign cause = why;

endmodule

// File: rtl/seg_resp_fsm.sv
module seg_resp_fsm #(
    parameter int PA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            chk_fail,
    input  logic [1:0]      chk_cause,
    input  logic [PA_W-1:0] chk_paddr,
    output logic            rsp_valid,
    output logic            rsp_trap,
    output logic [1:0]      rsp_cause,
    output logic [PA_W-1:0] rsp_paddr
);
    import segx_pkg::*;

    rsp_state_e      state_q;
    rsp_state_e      state_d;
    logic [PA_W-1:0] paddr_q;
    logic [1:0]      cause_q;

    always_comb begin
        if (!req_valid) begin
            state_d = RSP_IDLE;
        end else if (chk_fail) begin
            state_d = RSP_TRAP;
        end else begin
            state_d = RSP_PASS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            cause_q <= '0;
        end else begin
            unique case (state_d)
                RSP_PASS: begin
                    paddr_q <= chk_paddr;
                    cause_q <= '0;
                end
                RSP_TRAP: begin
                    paddr_q <= '0;
                    cause_q <= chk_cause;
                end
                default: begin
                    paddr_q <= '0;
                    cause_q <= '0;
                end
            endcase
        end
    end

    always_comb begin
        rsp_cause = cause_q;
        rsp_paddr = paddr_q;
        unique case (state_q)
            RSP_PASS: begin
                rsp_valid = 1'b1;
                rsp_trap  = 1'b0;
            end
            RSP_TRAP: begin
                rsp_valid = 1'b1;
                rsp_trap  = 1'b1;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_trap  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 10,
    parameter int PA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ent_we,
    input  logic [SEG_W-1:0]  cfg_ent_idx,
    input  logic [PA_W-1:0]   cfg_base,
    input  logic [OFF_W:0]    cfg_limit,
    input  logic              cfg_valid,
    input  logic [2:0]        cfg_perm,
    input  logic              cfg_len_we,
    input  logic [SEG_W:0]    cfg_len,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              rsp_valid,
    output logic              rsp_trap,
    output logic [1:0]        rsp_cause,
    output logic [PA_W-1:0]   rsp_paddr
);
    localparam int LIM_W = OFF_W + 1;

    logic [PA_W-1:0]  ent_base;
    logic [LIM_W-1:0] ent_limit;
    logic             ent_valid;
    logic [2:0]       ent_perm;
    logic [SEG_W:0]   len_q;
    logic             chk_fail;
    logic [1:0]       chk_cause;
    logic [PA_W-1:0]  chk_paddr;

    seg_table #(.SEG_W(SEG_W), .LIM_W(LIM_W), .PA_W(PA_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_we    (cfg_ent_we),
        .ent_idx   (cfg_ent_idx),
        .ent_base  (cfg_base),
        .ent_limit (cfg_limit),
        .ent_valid (cfg_valid),
        .ent_perm  (cfg_perm),
        .len_we    (cfg_len_we),
        .len_val   (cfg_len),
        .rd_idx    (req_seg),
        .rd_base   (ent_base),
        .rd_limit  (ent_limit),
        .rd_valid  (ent_valid),
        .rd_perm   (ent_perm),
        .len_q     (len_q)
    );

    seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .req_seg   (req_seg),
        .req_off   (req_off),
        .req_acc   (req_acc),
        .len_q     (len_q),
        .ent_base  (ent_base),
        .ent_limit (ent_limit),
        .ent_valid (ent_valid),
        .ent_perm  (ent_perm),
        .fail      (chk_fail),
        .cause     (chk_cause),
        .paddr     (chk_paddr)
    );

    seg_resp_fsm #(.PA_W(PA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .chk_fail  (chk_fail),
        .chk_cause (chk_cause),
        .chk_paddr (chk_paddr),
        .rsp_valid (rsp_valid),
        .rsp_trap  (rsp_trap),
        .rsp_cause (rsp_cause),
        .rsp_paddr (rsp_paddr)
    );

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
    parameter int SEG_W = 3,
    parameter int PA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_ent_we,
    input logic [SEG_W-1:0] cfg_ent_idx,
    input logic             cfg_valid,
    input logic             cfg_len_we,
    input logic [SEG_W:0]   cfg_len,
    input logic             req_valid,
    input logic [SEG_W-1:0] req_seg,
    input logic             rsp_valid,
    input logic             rsp_trap,
    input logic [1:0]       rsp_cause,
    input logic [PA_W-1:0]  rsp_paddr
);
    localparam int NSLOT = 1 << SEG_W;

    logic [SEG_W:0]   len_sh;
    logic [NSLOT-1:0] vld_sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_sh <= '0;
            vld_sh <= '0;
        end else begin
            if (cfg_len_we) len_sh <= cfg_len;
            if (cfg_ent_we) vld_sh[cfg_ent_idx] <= cfg_valid;
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3
    seg_range_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= len_sh)) |=> (rsp_trap && rsp_cause == 2'd0));

    // R4
    invalid_slot_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} < len_sh) && !vld_sh[req_seg])
        |=> (rsp_trap && rsp_cause == 2'd1));

    // R9
    trap_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_valid && rsp_paddr == '0));

endmodule

bind seg_xlat_unit seg_xlat_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ent_we  (cfg_ent_we),
    .cfg_ent_idx (cfg_ent_idx),
    .cfg_valid   (cfg_valid),
    .cfg_len_we  (cfg_len_we),
    .cfg_len     (cfg_len),
    .req_valid   (req_valid),
    .req_seg     (req_seg),
    .rsp_valid   (rsp_valid),
    .rsp_trap    (rsp_trap),
    .rsp_cause   (rsp_cause),
    .rsp_paddr   (rsp_paddr)
);

// File: tb/test_seg_xlat_unit.sv
module test_seg_xlat_unit;
    localparam int SEG_W = 3;
    localparam int OFF_W = 10;
    localparam int PA_W  = 16;
    localparam int NSLOT = 1 << SEG_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_ent_we = 1'b0;
    logic [SEG_W-1:0]  cfg_ent_idx = '0;
    logic [PA_W-1:0]   cfg_base = '0;
    logic [OFF_W:0]    cfg_limit = '0;
    logic              cfg_valid = 1'b0;
    logic [2:0]        cfg_perm = '0;
    logic              cfg_len_we = 1'b0;
    logic [SEG_W:0]    cfg_len = '0;
    logic              req_valid = 1'b0;
    logic [SEG_W-1:0]  req_seg = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic [1:0]        req_acc = '0;
    logic              rsp_valid;
    logic              rsp_trap;
    logic [1:0]        rsp_cause;
    logic [PA_W-1:0]   rsp_paddr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int m_base [NSLOT];
    int m_lim  [NSLOT];
    bit m_vld  [NSLOT];
    int m_perm [NSLOT];
    int m_len = 0;

    always #4 clk = ~clk;

    seg_xlat_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_seg_xlat_unit (
        .clk(clk), .rst_n(rst_n),
        .cfg_ent_we(cfg_ent_we), .cfg_ent_idx(cfg_ent_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_valid(cfg_valid), .cfg_perm(cfg_perm),
        .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model(input int seg, input int off, input int acc,
                                  output int trap, output int cause, output int pa);
        trap = 1; cause = 0; pa = 0;
        if (seg >= m_len) cause = 0;
        else if (!m_vld[seg]) cause = 1;
        else if (off >= m_lim[seg]) cause = 2;
        else if (acc == 3 || ((m_perm[seg] >> acc) & 1) == 0) cause = 3;
        else begin
            trap = 0;
            pa = (m_base[seg] + off) & ((1 << PA_W) - 1);
        end
    endfunction

    task automatic set_req(input int seg, input int off, input int acc);
        req_valid = 1'b1;
        req_seg = SEG_W'(seg);
        req_off = OFF_W'(off);
        req_acc = 2'(acc);
    endtask

    task automatic check_rsp(input string tag, input int trap, input int cause, input int pa);
        check({tag, " valid"}, int'(rsp_valid), 1);
        check({tag, " trap"}, int'(rsp_trap), trap);
        check({tag, " cause"}, int'(rsp_cause), cause);
        check({tag, " paddr"}, int'(rsp_paddr), pa);
    endtask

    task automatic xlat(input string tag, input int seg, input int off, input int acc);
        int t, c, p;
        model(seg, off, acc, t, c, p);
        set_req(seg, off, acc);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(tag, t, c, p);
    endtask

    task automatic wr_ent(input int idx, input int base, input int lim, input bit vld, input int perm);
        cfg_ent_we = 1'b1;
        cfg_ent_idx = SEG_W'(idx);
        cfg_base = PA_W'(base);
        cfg_limit = (OFF_W+1)'(lim);
        cfg_valid = vld;
        cfg_perm = 3'(perm);
        @(negedge clk);
        cfg_ent_we = 1'b0;
        m_base[idx] = base; m_lim[idx] = lim; m_vld[idx] = vld; m_perm[idx] = perm;
    endtask

    task automatic wr_len(input int len);
        cfg_len_we = 1'b1;
        cfg_len = (SEG_W+1)'(len);
        @(negedge clk);
        cfg_len_we = 1'b0;
        m_len = len;
    endtask

    task automatic t_reset;
        check("R1 reset rsp_valid", int'(rsp_valid), 0);
        xlat("R1 first translate after reset", 0, 0, 0);
    endtask

    task automatic t_program;
        wr_ent(0, 'h1000, 'h100, 1'b1, 3'b111);
        wr_ent(1, 'h2000, 'h040, 1'b1, 3'b001);
        wr_ent(2, 'h3000, 'h400, 1'b1, 3'b100);
        wr_ent(3, 'h4000, 'h010, 1'b0, 3'b111);
        wr_ent(4, 'hFF00, 'h200, 1'b1, 3'b011);
        for (int i = 5; i < NSLOT; i++) wr_ent(i, 'h5000, 'h10, 1'b1, 3'b111);
        wr_len(5);
    endtask

    task automatic t_pass;
        xlat("R8 pass e0 last offset (R5 boundary)", 0, 'h0FF, 0);
        xlat("R8 pass e1 read", 1, 'h3F, 0);
        xlat("R8 pass e2 exec full length", 2, 'h3FF, 2);
        xlat("R8 pass e4 wraps", 4, 'h1F0, 1);
        xlat("R3 last legal segment passes", 4, 0, 0);
    endtask

    task automatic t_traps;
        xlat("R5 offset equals length", 0, 'h100, 0);
        xlat("R6 write without permission", 1, 0, 1);
        xlat("R6 reserved access type", 2, 0, 3);
        xlat("R6 read on exec-only", 2, 0, 0);
        xlat("R4 invalid slot", 3, 0, 0);
        xlat("R3 valid slot beyond length", 5, 0, 0);
        xlat("R9 trap address zero", 7, 'h3FF, 2);
    endtask

    task automatic t_priority;
        xlat("R7 invalid beats offset", 3, 'h3FF, 3);
        xlat("R7 offset beats permission", 1, 'h040, 1);
        xlat("R7 range beats all", 6, 'h3FF, 3);
    endtask

    task automatic t_same_cycle;
        int t, c, p;
        // R10: descriptor write and translate of that slot on the same edge
        model(0, 'h10, 0, t, c, p);
        set_req(0, 'h10, 0);
        cfg_ent_we = 1'b1; cfg_ent_idx = 0; cfg_base = 'h7000;
        cfg_limit = 'h100; cfg_valid = 1'b1; cfg_perm = 3'b111;
        @(negedge clk);
        cfg_ent_we = 1'b0; req_valid = 1'b0;
        m_base[0] = 'h7000;
        check_rsp("R10 same-cycle sees old descriptor", t, c, p);
        xlat("R10 next cycle sees new descriptor", 0, 'h10, 0);
        xlat("R11 neighbour slot untouched", 1, 'h20, 0);
        // R10: length write and translate just past the old length
        model(5, 0, 0, t, c, p);
        set_req(5, 0, 0);
        cfg_len_we = 1'b1; cfg_len = 6;
        @(negedge clk);
        cfg_len_we = 1'b0; req_valid = 1'b0;
        m_len = 6;
        check_rsp("R10 same-cycle sees old length", t, c, p);
        xlat("R10 new length applies", 5, 'h0F, 1);
    endtask

    task automatic t_stream;
        int t1, c1, p1, t2, c2, p2;
        model(1, 4, 0, t1, c1, p1);
        model(3, 0, 0, t2, c2, p2);
        set_req(1, 4, 0);
        @(negedge clk);
        check_rsp("R2 burst first", t1, c1, p1);
        set_req(3, 0, 0);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R2 burst second", t2, c2, p2);
        @(negedge clk);
        check("R2 idle after burst", int'(rsp_valid), 0);
    endtask

    initial begin
        for (int i = 0; i < NSLOT; i++) begin
            m_base[i] = 0; m_lim[i] = 0; m_vld[i] = 1'b0; m_perm[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_program;
        t_pass;
        t_traps;
        t_priority;
        t_same_cycle;
        t_stream;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule